// File: doc/BRIEF.md
# Operand Bypass and Load Hazard Controller

This block is the hazard control for an in-order integer pipeline with five stages. It looks only at register indices and per-stage flags: the source indices of the instruction waiting in decode, the sources, destination, write flag and load flag held in the decode/execute register, and the destination and write flag held in each of the two later pipeline registers. It returns no data. Its outputs are a bypass selection for each of the two ALU operands and the control that freezes the front of the pipe.

A producer whose result already sits in the execute/memory or memory/writeback register is bypassed to the consumer now in execute. When both later registers hold a result for the same source, the execute/memory one wins because it is the more recent. A load cannot forward to the instruction right behind it. That case is caught while the consumer is still in decode. For one cycle the block then stops the program counter and the fetch/decode register and turns the next decode/execute control into a bubble.

The register file writes before it reads within a cycle. A decode source that matches the writeback destination is therefore left to the register file and produces neither a stall nor a bypass. Register index 0 is hardwired to zero and never takes part in any comparison. The clock and active-low reset inputs serve only the built-in property checks.

Top module: `hazard_ctrl`

## Requirements
- R1: Bypass select encoding per operand: 0 = register file value, 1 = execute/memory result, 2 = memory/writeback result; value 3 never appears. When a decode/execute source equals the execute/memory destination and that stage's write flag is 1, the select is 1.
- R2: When a decode/execute source matches only the memory/writeback destination and that stage's write flag is 1, the select is 2.
- R3: When both later stages match the same source with write flags set, the select is 1.
- R4: Register index 0 never produces a non-zero select and never causes a stall.
- R5: A stage whose write flag is 0 causes neither a bypass nor a stall, even when its destination matches.
- R6: A stall occurs when the decode/execute instruction is a load (load flag 1, write flag 1, destination non-zero) and decode source 1 is in use and equals that destination. During the stall the program-counter write enable is 0, the fetch/decode write enable is 0 and the bubble output is 1.
- R7: The same stall occurs for decode source 2 when its use flag is 1. Stores and register-register instructions raise this flag.
- R8: A matching decode source whose use flag is 0 does not stall.
- R9: A producer in decode/execute that is not a load never causes a stall.
- R10: A decode source that equals the memory/writeback destination causes no stall.
- R11: The two operand selects are decided independently and may differ in the same cycle.
- R12: With no stall, both write enables are 1 and the bubble output is 0. This includes the idle state after reset with all inputs at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the property checks |
| rst_n | input | 1 | Active-low reset for the property checks |
| id_rs1 | input | AW | Source 1 index of the instruction in decode |
| id_rs2 | input | AW | Source 2 index of the instruction in decode |
| id_rs1_used | input | 1 | Decode instruction reads source 1 |
| id_rs2_used | input | 1 | Decode instruction reads source 2 (also for store data) |
| ex_rs1 | input | AW | Source 1 index held in decode/execute |
| ex_rs2 | input | AW | Source 2 index held in decode/execute |
| ex_rd | input | AW | Destination held in decode/execute |
| ex_reg_we | input | 1 | Write flag held in decode/execute |
| ex_is_load | input | 1 | Decode/execute instruction is a load |
| mem_rd | input | AW | Destination held in execute/memory |
| mem_reg_we | input | 1 | Write flag held in execute/memory |
| wb_rd | input | AW | Destination held in memory/writeback |
| wb_reg_we | input | 1 | Write flag held in memory/writeback |
| fwd_a | output | 2 | Bypass select for ALU operand 1 |
| fwd_b | output | 2 | Bypass select for ALU operand 2 |
| pc_we | output | 1 | Program counter write enable, 0 while stalled |
| ifid_we | output | 1 | Fetch/decode register write enable, 0 while stalled |
| idex_bubble | output | 1 | Forces decode/execute control to a no-op |

## Verification
The property checks run on every cycle. They cover the priority of the execute/memory result when both stages match, the exclusion of register 0 from bypass and stall, the absence of the unused select code, and the rule that only a load raises a stall. Other behaviour can only be shown by the bench's scenarios: the use flags gating the stall, the write-before-read case that must not stall, independent selection of the two operands, and the three-cycle sequence of stall, bubble and then bypass from writeback.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  // Operand source selection for the widened ALU input multiplexers
  typedef enum logic [1:0] {
    SRC_RF    = 2'd0,
    SRC_EXMEM = 2'd1,
    SRC_MEMWB = 2'd2
  } byp_src_e;

  localparam int unsigned NUM_ALU_SRC = 2;
endpackage

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel
  import hazard_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] src_idx,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_we,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_we,
  output byp_src_e      sel
);
  localparam logic [AW-1:0] ZERO_IDX = '0;

  // A stage hits when it writes a real register equal to the source
  function automatic logic stage_hit(input logic [AW-1:0] dst,
                                     input logic          we,
                                     input logic [AW-1:0] src);
    return we && (dst != ZERO_IDX) && (dst == src);
  endfunction

  logic hit_mem;
  logic hit_wb;

  assign hit_mem = stage_hit(mem_rd, mem_we, src_idx);
  assign hit_wb  = stage_hit(wb_rd, wb_we, src_idx);

  always_comb begin
    if (hit_mem)     sel = SRC_EXMEM;
    else if (hit_wb) sel = SRC_MEMWB;
    else             sel = SRC_RF;
  end

  // R3
  younger_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_mem && hit_wb) |-> (sel == SRC_EXMEM));

  // R4
  zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_idx == ZERO_IDX) |-> (sel == SRC_RF));

  // R1
  legal_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != 2'd3));
endmodule

// File: rtl/load_use_detect.sv
module load_use_detect
  import hazard_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] id_src   [NUM_ALU_SRC],
  input  logic          id_used  [NUM_ALU_SRC],
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_we,
  input  logic          ex_load,
  output logic          stall
);
  localparam logic [AW-1:0] ZERO_IDX = '0;

  // Load result not ready in time for a reader one stage behind
  function automatic logic load_blocks(input logic [AW-1:0] dst,
                                       input logic          we,
                                       input logic          ld,
                                       input logic [AW-1:0] src,
                                       input logic          used);
    return ld && we && used && (dst != ZERO_IDX) && (dst == src);
  endfunction

  logic [NUM_ALU_SRC-1:0] src_blocked;

  for (genvar g = 0; g < NUM_ALU_SRC; g++) begin : g_src
    assign src_blocked[g] = load_blocks(ex_rd, ex_we, ex_load, id_src[g], id_used[g]);
  end

  assign stall = |src_blocked;

  // R9
  only_load_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ex_load) |-> (!stall));

  // R4
  zero_dst_nostall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rd == ZERO_IDX) |-> (!stall));
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hazard_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic          id_rs1_used,
  input  logic          id_rs2_used,
  input  logic [AW-1:0] ex_rs1,
  input  logic [AW-1:0] ex_rs2,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_reg_we,
  input  logic          ex_is_load,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_reg_we,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_reg_we,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          pc_we,
  output logic          ifid_we,
  output logic          idex_bubble
);
  logic [AW-1:0] ex_src  [NUM_ALU_SRC];
  logic [AW-1:0] id_src  [NUM_ALU_SRC];
  logic          id_used [NUM_ALU_SRC];
  byp_src_e      op_sel  [NUM_ALU_SRC];
  logic          load_stall;

  assign ex_src[0]  = ex_rs1;
  assign ex_src[1]  = ex_rs2;
  assign id_src[0]  = id_rs1;
  assign id_src[1]  = id_rs2;
  assign id_used[0] = id_rs1_used;
  assign id_used[1] = id_rs2_used;

  // One bypass selector per ALU operand
  for (genvar g = 0; g < NUM_ALU_SRC; g++) begin : g_op
    fwd_operand_sel #(.AW(AW)) u_sel (
      .clk     (clk),
      .rst_n   (rst_n),
      .src_idx (ex_src[g]),
      .mem_rd  (mem_rd),
      .mem_we  (mem_reg_we),
      .wb_rd   (wb_rd),
      .wb_we   (wb_reg_we),
      .sel     (op_sel[g])
    );
  end

  load_use_detect #(.AW(AW)) u_lu (
    .clk     (clk),
    .rst_n   (rst_n),
    .id_src  (id_src),
    .id_used (id_used),
    .ex_rd   (ex_rd),
    .ex_we   (ex_reg_we),
    .ex_load (ex_is_load),
    .stall   (load_stall)
  );

  assign fwd_a       = op_sel[0];
  assign fwd_b       = op_sel[1];
  assign pc_we       = !load_stall;
  assign ifid_we     = !load_stall;
  assign idex_bubble = load_stall;
endmodule

// File: tb/hazard_ctrl_test.sv
module hazard_ctrl_test;
  localparam int AW = 5;

  typedef struct {
    int    fa;
    int    fb;
    bit    stall;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] id_rs1 = '0, id_rs2 = '0, ex_rs1 = '0, ex_rs2 = '0;
  logic [AW-1:0] ex_rd = '0, mem_rd = '0, wb_rd = '0;
  logic id_rs1_used = 1'b0, id_rs2_used = 1'b0;
  logic ex_reg_we = 1'b0, ex_is_load = 1'b0, mem_reg_we = 1'b0, wb_reg_we = 1'b0;
  logic [1:0] fwd_a, fwd_b;
  logic pc_we, ifid_we, idex_bubble;

  exp_t q[$];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hazard_ctrl #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n),
    .id_rs1(id_rs1), .id_rs2(id_rs2),
    .id_rs1_used(id_rs1_used), .id_rs2_used(id_rs2_used),
    .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd),
    .ex_reg_we(ex_reg_we), .ex_is_load(ex_is_load),
    .mem_rd(mem_rd), .mem_reg_we(mem_reg_we),
    .wb_rd(wb_rd), .wb_reg_we(wb_reg_we),
    .fwd_a(fwd_a), .fwd_b(fwd_b),
    .pc_we(pc_we), .ifid_we(ifid_we), .idex_bubble(idex_bubble)
  );

  // Expected select from the requirement text: younger stage first, x0 excluded
  function automatic int want_sel(int rs, int mrd, bit mwe, int wrd, bit wwe);
    if (rs == 0) return 0;
    if (mwe && (mrd == rs)) return 1;
    if (wwe && (wrd == rs)) return 2;
    return 0;
  endfunction

  task automatic drive(input int i1, input int i2, input bit u1, input bit u2,
                       input int e1, input int e2, input int erd, input bit ewe,
                       input bit eld, input int mrd, input bit mwe,
                       input int wrd, input bit wwe, input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    id_rs1 = i1[AW-1:0]; id_rs2 = i2[AW-1:0];
    id_rs1_used = u1; id_rs2_used = u2;
    ex_rs1 = e1[AW-1:0]; ex_rs2 = e2[AW-1:0]; ex_rd = erd[AW-1:0];
    ex_reg_we = ewe; ex_is_load = eld;
    mem_rd = mrd[AW-1:0]; mem_reg_we = mwe;
    wb_rd = wrd[AW-1:0]; wb_reg_we = wwe;
    e.fa = want_sel(e1, mrd, mwe, wrd, wwe);
    e.fb = want_sel(e2, mrd, mwe, wrd, wwe);
    e.stall = eld && ewe && (erd != 0) &&
              ((u1 && (i1 == erd)) || (u2 && (i2 == erd)));
    e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compare away from the active edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      int   act_stall;
      e = q.pop_front();
      checks++;
      act_stall = (!pc_we && !ifid_we && idex_bubble) ? 1 :
                  (pc_we && ifid_we && !idex_bubble) ? 0 : 9;
      if (int'(fwd_a) != e.fa || int'(fwd_b) != e.fb || act_stall != int'(e.stall)) begin
        fails++;
        $display("FAIL %s: fwd_a=%0d fwd_b=%0d stall=%0d expected fwd_a=%0d fwd_b=%0d stall=%0d",
                 e.tag, fwd_a, fwd_b, act_stall, e.fa, e.fb, e.stall);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R12 idle state during reset with all inputs zero
    drive(0,0,0,0, 0,0,0,0,0, 0,0, 0,0, "R12 reset idle");
    drive(0,0,0,0, 0,0,0,0,0, 0,0, 0,0, "R12 reset idle");
    rst_n = 1'b1;
    drive(0,0,0,0, 0,0,0,0,0, 0,0, 0,0, "R12 idle after reset");
    // R1 execute/memory hit on operand 1
    drive(0,0,0,0, 3,8,0,0,0, 3,1, 0,0, "R1 exmem bypass");
    // R2 memory/writeback hit on operand 2
    drive(0,0,0,0, 1,4,0,0,0, 9,1, 4,1, "R2 memwb bypass");
    // R3 both stages match
    drive(0,0,0,0, 5,5,0,0,0, 5,1, 5,1, "R3 younger priority");
    // R4 register zero
    drive(0,0,1,1, 0,0,0,1,1, 0,1, 0,1, "R4 x0 ignored");
    // R5 write flag low
    drive(0,0,0,0, 6,6,0,0,0, 6,0, 6,0, "R5 no write no bypass");
    drive(7,0,1,0, 0,0,7,0,1, 0,0, 0,0, "R5 no write no stall");
    // R6 load-use on source 1, then bubble, then bypass from writeback
    drive(7,2,1,1, 0,0,7,1,1, 0,0, 0,0, "R6 load-use rs1");
    drive(7,2,1,1, 0,0,0,0,0, 7,1, 0,0, "R6 bubble cycle no stall");
    drive(0,0,0,0, 7,2,0,0,0, 0,0, 7,1, "R6 consumer gets memwb");
    // R7 store data source
    drive(1,7,1,1, 0,0,7,1,1, 0,0, 0,0, "R7 load-use rs2");
    // R8 unused field
    drive(1,7,1,0, 0,0,7,1,1, 0,0, 0,0, "R8 unused rs2 no stall");
    drive(7,1,0,1, 0,0,7,1,1, 0,0, 0,0, "R8 unused rs1 no stall");
    // R9 non-load producer
    drive(7,7,1,1, 0,0,7,1,0, 0,0, 0,0, "R9 alu producer no stall");
    // R10 write-before-read
    drive(9,9,1,1, 0,0,3,1,0, 0,0, 9,1, "R10 wb match no stall");
    // R11 independent operands
    drive(0,0,0,0, 3,6,0,0,0, 3,1, 6,1, "R11 mixed selects");
    drive(0,0,0,0, 6,3,0,0,0, 3,1, 6,1, "R11 swapped selects");
    // Sweep of indices across both bypass paths
    for (int r = 1; r < 32; r++) begin
      drive(r, (r+1)%32, 1, 1, r, (r+3)%32, r, 1, (r%2)==1,
            r, (r%3)!=0, (r+3)%32, 1, "R1 R2 R6 sweep");
    end
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule